// File: doc/BRIEF.md
# Completion Error Discard Filter

This block sits between a requester completion stream and the user logic that consumes it. Each packet on the stream opens with a descriptor beat and may carry payload beats after it. The filter reads the error code, the request-completed flag, the tag and the function number from every descriptor. It decides beat by beat what may be passed on, removes payload that must not be used, and tells the request tracker when to close out a request and when the tag may be handed out again.

Some errors split the life of a request. An error can close the request while further split completions for the same tag are still in flight. The filter keeps one discard flag per tag, 256 in all. It uses these flags to swallow the stale completions and holds back tag release until a descriptor with the completed flag set arrives. For each error code it also keeps a saturating count of the packets it had to trim or drop.

Top module: `cmplErrFilter`

## Requirements
- R1: After reset, outValid, abortValid and releaseValid are low, every drop count is zero and no tag is marked as discarding.
- R2: The first beat of a packet is its descriptor and the beat with inLast high ends it. In the descriptor the error code sits in bits [15:12], the completed flag in bit 30, the function in bits [55:48] and the tag in bits [71:64]. Forwarded beats appear on outData unchanged, in the same cycle.
- R3: For codes 0100, 0101, 0110 and 1000 the descriptor is forwarded with outLast high and every payload beat of that packet is dropped.
- R4: Code 0100 or 0101 with the completed flag clear marks the tag as discarding. A later packet for a discarding tag, with the flag clear and a code other than 0110, is dropped whole: descriptor and payload.
- R5: A packet for a discarding tag with the completed flag set has its descriptor forwarded with outLast high and its payload dropped. The tag's discard flag clears at the edge that accepts it, and the packet raises no abort.
- R6: Code 0110 changes no discard flag and raises neither strobe.
- R7: abortValid is high for the one cycle that follows the edge accepting a descriptor whose code is nonzero and not 0110, on a tag that is not discarding. eventTag and eventFunc then hold that descriptor's tag and function.
- R8: releaseValid is high for the one cycle that follows the edge accepting a descriptor with the completed flag set and a code other than 0110, and never otherwise. It may coincide with abortValid.
- R9: A beat that is dropped is accepted (inReady high) whatever outReady is. A beat that is kept waits for outReady.
- R10: For each code k, dropCount[k*CNT_W +: CNT_W] counts the packets with that descriptor code in which at least one beat was dropped. At 2^CNT_W-1 the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | DATA_W | Incoming completion beat |
| inValid | input | 1 | Incoming beat valid |
| inLast | input | 1 | Incoming beat ends the packet |
| inReady | output | 1 | Filter accepts the incoming beat |
| outData | output | DATA_W | Forwarded beat |
| outValid | output | 1 | Forwarded beat valid |
| outLast | output | 1 | Forwarded beat ends the packet |
| outReady | input | 1 | Consumer accepts the forwarded beat |
| abortValid | output | 1 | One-cycle request close-out strobe |
| releaseValid | output | 1 | One-cycle tag release strobe |
| eventTag | output | 8 | Tag belonging to the strobes |
| eventFunc | output | 8 | Function belonging to the strobes |
| dropCount | output | 16*CNT_W | Saturating drop count per error code |

## Verification
Close-out and tag release fall in the same cycle when a terminating code (0010, 0011, 0111, 1000) arrives with the completed flag set. They separate when 0100 or 0101 arrives with the flag clear, and then again when a later completed descriptor reaches a discarding tag. The bench sweeps every code against both flag values, zero to two payload beats, a few reused tags and stalled or free output. Because the tags repeat, discard state carries from one packet to the next. A model in the bench predicts, for each descriptor, both strobes and which beats survive. It compares these at the falling edge after acceptance and also checks a counter driven into saturation.

// File: rtl/cefPkg.sv
package cefPkg;
  localparam int CODE_W   = 4;
  localparam int TAG_W    = 8;
  localparam int FUNC_W   = 8;
  localparam int NUM_TAGS = 1 << TAG_W;
  localparam int NUM_CODES = 1 << CODE_W;

  // descriptor field positions
  localparam int CODE_LSB = 12;
  localparam int DONE_BIT = 30;
  localparam int FUNC_LSB = 48;
  localparam int TAG_LSB  = 64;
  localparam int DESC_MIN_W = TAG_LSB + TAG_W;

  localparam logic [CODE_W-1:0] CODE_NONE     = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_MISMATCH = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_ADDR     = 4'b0101;
  localparam logic [CODE_W-1:0] CODE_BADTAG   = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_DUMMY    = 4'b1000;

  // control-to-datapath strobes for the current beat
  typedef struct packed {
    logic sop;        // beat is a descriptor
    logic keep;       // beat is forwarded
    logic endOut;     // forwarded beat carries outLast
    logic doAbort;    // descriptor closes out its request
    logic doRelease;  // descriptor frees its tag
    logic countDrop;  // packet loses at least one beat
  } ctrlStrobe_t;
endpackage

// File: rtl/cefCtrl.sv
module cefCtrl
  import cefPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              beatFire,
  input  logic              inLast,
  input  logic [CODE_W-1:0] code,
  input  logic              doneFlag,
  input  logic [TAG_W-1:0]  tag,
  output ctrlStrobe_t       strb
);
  logic                midPkt;
  logic                pktDrop;
  logic [NUM_TAGS-1:0] discTable;

  logic tagDisc, stale, payCode, dropRest, keepDesc, setDisc, clrDisc;

  always_comb begin
    tagDisc  = discTable[tag];
    stale    = tagDisc && (code != CODE_BADTAG);
    payCode  = (code == CODE_MISMATCH) || (code == CODE_ADDR) ||
               (code == CODE_BADTAG)   || (code == CODE_DUMMY);
    dropRest = payCode || stale;
    keepDesc = !(stale && !doneFlag);
    setDisc  = ((code == CODE_MISMATCH) || (code == CODE_ADDR)) && !doneFlag;
    clrDisc  = stale && doneFlag;

    strb.sop       = !midPkt;
    strb.keep      = midPkt ? !pktDrop : keepDesc;
    strb.endOut    = midPkt ? inLast : (inLast || dropRest);
    strb.doAbort   = !midPkt && (code != CODE_NONE) && (code != CODE_BADTAG) && !stale;
    strb.doRelease = !midPkt && doneFlag && (code != CODE_BADTAG);
    strb.countDrop = !midPkt && (!keepDesc || (dropRest && !inLast));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midPkt    <= 1'b0;
      pktDrop   <= 1'b0;
      discTable <= '0;
    end else if (beatFire) begin
      midPkt <= !inLast;
      if (!midPkt) begin
        pktDrop <= dropRest;
        if (setDisc)      discTable[tag] <= 1'b1;
        else if (clrDisc) discTable[tag] <= 1'b0;
      end
    end
  end

  AST_DISC_SET: assert property (@(posedge clk) disable iff (!rstN)
    beatFire && !midPkt && ((code == CODE_MISMATCH) || (code == CODE_ADDR)) && !doneFlag
    |=> discTable[$past(tag)]);  // R4

  AST_DISC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    beatFire && !midPkt && discTable[tag] && (code != CODE_BADTAG) && doneFlag
    |=> !discTable[$past(tag)]);  // R5

  AST_BADTAG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    beatFire && !midPkt && (code == CODE_BADTAG) |=> $stable(discTable));  // R6

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    beatFire && midPkt |=> $stable(discTable));  // R2
endmodule

// File: rtl/cefData.sv
module cefData
  import cefPkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DATA_W-1:0]         inData,
  input  logic                      inValid,
  input  logic                      inLast,
  output logic                      inReady,
  output logic [DATA_W-1:0]         outData,
  output logic                      outValid,
  output logic                      outLast,
  input  logic                      outReady,
  input  ctrlStrobe_t               strb,
  output logic                      beatFire,
  output logic [CODE_W-1:0]         code,
  output logic                      doneFlag,
  output logic [TAG_W-1:0]          tag,
  output logic                      abortValid,
  output logic                      releaseValid,
  output logic [TAG_W-1:0]          eventTag,
  output logic [FUNC_W-1:0]         eventFunc,
  output logic [NUM_CODES*CNT_W-1:0] dropCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [FUNC_W-1:0] func;

  assign code     = inData[CODE_LSB +: CODE_W];
  assign doneFlag = inData[DONE_BIT];
  assign tag      = inData[TAG_LSB +: TAG_W];
  assign func     = inData[FUNC_LSB +: FUNC_W];

  assign outData  = inData;
  assign outValid = inValid && strb.keep;
  assign outLast  = strb.endOut;
  assign inReady  = outReady || !strb.keep;
  assign beatFire = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortValid   <= 1'b0;
      releaseValid <= 1'b0;
      eventTag     <= '0;
      eventFunc    <= '0;
    end else begin
      abortValid   <= beatFire && strb.doAbort;
      releaseValid <= beatFire && strb.doRelease;
      if (beatFire && strb.sop) begin
        eventTag  <= tag;
        eventFunc <= func;
      end
    end
  end

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) cnt <= '0;
      else if (beatFire && strb.countDrop && (code == CODE_W'(k)) && (cnt != CNT_MAX))
        cnt <= cnt + 1'b1;
    end
    assign dropCount[k*CNT_W +: CNT_W] = cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      cnt == CNT_MAX |=> cnt == CNT_MAX);  // R10
  end

  AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> ($past(code) != CODE_NONE) && ($past(code) != CODE_BADTAG));  // R7

  AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |-> $past(doneFlag) && $past(beatFire));  // R8
endmodule

// File: rtl/cmplErrFilter.sv
module cmplErrFilter
  import cefPkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DATA_W-1:0]          inData,
  input  logic                       inValid,
  input  logic                       inLast,
  output logic                       inReady,
  output logic [DATA_W-1:0]          outData,
  output logic                       outValid,
  output logic                       outLast,
  input  logic                       outReady,
  output logic                       abortValid,
  output logic                       releaseValid,
  output logic [7:0]                 eventTag,
  output logic [7:0]                 eventFunc,
  output logic [16*CNT_W-1:0]        dropCount
);
  ctrlStrobe_t       strb;
  logic              beatFire;
  logic [CODE_W-1:0] code;
  logic              doneFlag;
  logic [TAG_W-1:0]  tag;

  cefCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .beatFire (beatFire),
    .inLast   (inLast),
    .code     (code),
    .doneFlag (doneFlag),
    .tag      (tag),
    .strb     (strb)
  );

  cefData #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .inData       (inData),
    .inValid      (inValid),
    .inLast       (inLast),
    .inReady      (inReady),
    .outData      (outData),
    .outValid     (outValid),
    .outLast      (outLast),
    .outReady     (outReady),
    .strb         (strb),
    .beatFire     (beatFire),
    .code         (code),
    .doneFlag     (doneFlag),
    .tag          (tag),
    .abortValid   (abortValid),
    .releaseValid (releaseValid),
    .eventTag     (eventTag),
    .eventFunc    (eventFunc),
    .dropCount    (dropCount)
  );
endmodule

// File: tb/cmplErrFilter_tb.sv
`timescale 1ns/1ps
module cmplErrFilter_tb;
  localparam int DW = 128;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0, outReady = 1'b1;
  logic inReady, outValid, outLast, abortValid, releaseValid;
  logic [DW-1:0] outData;
  logic [7:0] eventTag, eventFunc;
  logic [16*CW-1:0] dropCount;

  cmplErrFilter #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid), .outLast(outLast),
    .outReady(outReady), .abortValid(abortValid), .releaseValid(releaseValid),
    .eventTag(eventTag), .eventFunc(eventFunc), .dropCount(dropCount));

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  bit [255:0] disc = '0;
  int expCnt[16];
  bit pendA = 0, pendR = 0;
  logic [7:0] pendTag = '0, pendFunc = '0;
  string labA = "R7";

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkStrobes();
    chk(abortValid == pendA, labA, 128'(abortValid), 128'(pendA));
    chk(releaseValid == pendR, (labA == "R6") ? "R6" : "R8", 128'(releaseValid), 128'(pendR));
    if (pendA || pendR) begin
      chk(eventTag == pendTag, "R7", 128'(eventTag), 128'(pendTag));
      chk(eventFunc == pendFunc, "R7", 128'(eventFunc), 128'(pendFunc));
    end
    pendA = 0; pendR = 0; labA = "R7";
  endtask

  task automatic beat(input logic [DW-1:0] d, input bit lst, input bit expKeep,
                      input bit expLast, input bit stall, input string req);
    @(negedge clk);
    checkStrobes();
    inData = d; inLast = lst; inValid = 1'b1; outReady = !stall;
    #1;
    chk(outValid == expKeep, req, 128'(outValid), 128'(expKeep));
    if (expKeep) begin
      chk(outData == d, "R2", outData, d);
      chk(outLast == expLast, req, 128'(outLast), 128'(expLast));
    end
    if (stall) begin
      chk(inReady == !expKeep, "R9", 128'(inReady), 128'(!expKeep));
      if (expKeep) begin
        @(negedge clk);
        checkStrobes();
        outReady = 1'b1;
        #1;
      end
    end
    @(posedge clk);
  endtask

  function automatic logic [DW-1:0] mkDesc(input [3:0] code, input bit dn, input [7:0] tag, input [7:0] fn);
    logic [DW-1:0] d = {4{32'h5A3C_96E1}} ^ {120'(0), tag};
    d[15:12] = code;
    d[30]    = dn;
    d[55:48] = fn;
    d[71:64] = tag;
    return d;
  endfunction

  task automatic sendPkt(input [3:0] code, input bit dn, input [7:0] tag, input int nPay, input bit stall);
    bit stale    = disc[tag] && code != 4'd6;
    bit payCode  = code == 4'd4 || code == 4'd5 || code == 4'd6 || code == 4'd8;
    bit dropRest = payCode || stale;
    bit keepDesc = !(stale && !dn);
    bit expAbort = code != 0 && code != 4'd6 && !stale;
    bit expRel   = dn && code != 4'd6;
    logic [7:0] fn = tag ^ 8'h3C;
    string rq = stale ? (dn ? "R5" : "R4") : (payCode ? "R3" : "R2");
    beat(mkDesc(code, dn, tag, fn), nPay == 0, keepDesc, (nPay == 0) || dropRest, stall, rq);
    pendA = expAbort; pendR = expRel; pendTag = tag; pendFunc = fn;
    labA = (code == 4'd6) ? "R6" : "R7";
    if ((code == 4'd4 || code == 4'd5) && !dn) disc[tag] = 1'b1;
    else if (stale && dn) disc[tag] = 1'b0;
    if (!keepDesc || (dropRest && nPay > 0))
      if (expCnt[code] < CMAX) expCnt[code]++;
    for (int p = 0; p < nPay; p++)
      beat({DW{1'b0}} | {32'(p), 32'hC0DE_0000, 32'(tag), 32'(code)}, p == nPay - 1,
           !dropRest, p == nPay - 1, stall, rq);
  endtask

  task automatic checkCounts();
    for (int k = 0; k < 16; k++)
      chk(dropCount[k*CW +: CW] == CW'(expCnt[k]), "R10", 128'(dropCount[k*CW +: CW]), 128'(expCnt[k]));
  endtask

  initial begin
    for (int k = 0; k < 16; k++) expCnt[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk(outValid == 0, "R1", 128'(outValid), 0);
    chk(abortValid == 0 && releaseValid == 0, "R1", 128'({abortValid, releaseValid}), 0);
    chk(dropCount == '0, "R1", dropCount, 0);
    // R1: no tag discarding - code 0 packets on several tags pass whole
    for (int t = 0; t < 4; t++) sendPkt(4'd0, 1'b0, 8'(t * 61), 1, 1'b0);

    // directed R4/R5 sequence on one tag
    sendPkt(4'd5, 1'b0, 8'h77, 2, 1'b0);
    sendPkt(4'd0, 1'b0, 8'h77, 1, 1'b1);
    sendPkt(4'd2, 1'b0, 8'h77, 0, 1'b0);
    sendPkt(4'd0, 1'b1, 8'h77, 1, 1'b1);
    sendPkt(4'd0, 1'b1, 8'h77, 1, 1'b0);

    // sweep codes x flag x payload length x reused tags x stall
    for (int i = 0; i < 192; i++)
      sendPkt(4'(i % 16), ((i / 16) % 2) == 1, 8'h10 + 8'(i % 5), (i / 32) % 3, (i % 3) == 0);
    sendPkt(4'd6, 1'b1, 8'h11, 1, 1'b0);
    checkCounts();

    // R10: drive the 0110 counter into saturation
    for (int i = 0; i < 260; i++) sendPkt(4'd6, 1'b0, 8'hE0, 1, 1'b0);
    @(negedge clk);
    checkStrobes();
    inValid = 1'b0;
    @(negedge clk);
    checkStrobes();
    chk(dropCount[6*CW +: CW] == CW'(CMAX), "R10", 128'(dropCount[6*CW +: CW]), 128'(CMAX));
    checkCounts();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule